// File: doc/BRIEF.md
# Management Data Serial Slave with Interrupt Output

This block is the register side of a physical-layer transceiver's serial management port. It runs on the management clock and samples the data line on every rising edge. It decodes write and read frames addressed to its own strapped address or to the broadcast address. It answers reads by driving the line through an output enable. Writes land in a small register file that holds control, status, vendor and interrupt registers.

The interrupt register combines eight sticky event flags with eight enable bits. Event strobes from the surrounding logic set the flags. A read of the register clears them. Whenever an enabled flag is set, the block drives an interrupt pin whose active level comes from a vendor-register bit. When no enabled flag is set, the pin is released, so the driver acts as an open-drain output. A control bit returns every register to its default.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While reset is high, and after it, `mdio_oe` and `intr_oe` are low, `ctrl_q` equals CTRL_DEF, `vend_q` equals VEND_DEF and `irq_q` is zero.
- R2: One preamble bit of value 1 before the start pattern 0,1 is enough to begin a frame. A 32-bit preamble also works.
- R3: After the start pattern the frame carries these fields, each most significant bit first: a 2-bit opcode, the 5-bit device address, the 5-bit register address, 2 turnaround bits and 16 data bits. Opcode 10 is a read and 01 is a write. The opcodes 00 and 11 cause the whole frame to be ignored.
- R4: Device address 00000 is accepted for both reads and writes, whatever the strap value.
- R5: When the device address is neither the strap value nor zero, `mdio_oe` stays low for the whole frame, so a pulled-up line reads 16'hFFFF, and a write has no effect.
- R6: On an accepted read, `mdio_oe` is low during the first turnaround bit. It rises with `mdio_o`=0 for the second turnaround bit, then carries the 16 data bits most significant bit first. It falls after the last data bit, having been high for 17 bit periods.
- R7: A write takes effect on the rising edge that samples the sixteenth data bit, and not before.
- R8: Register addresses 0 (control), 1 (status, read-only, value STAT_VAL), 16 (vendor) and 17 (interrupt) are implemented. Every other address reads as zero and ignores writes. Writes to address 1 are ignored.
- R9: In register 17, bits [7:0] are event flags set by `irq_evt`, and bits [15:8] are their enables. `intr_oe` rises one clock after an enabled flag becomes set. It stays low for flags that are not enabled.
- R10: While `intr_oe` is high, `intr_o` equals bit 14 of the vendor register: 1 means active high, 0 means active low.
- R11: An accepted read of register 17 returns the flags as they stood, then clears them. An event strobe on the same edge as the clear stays set.
- R12: Writing register 0 with bit 15 set returns every register to its default, and bit 15 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_i | input | 1 | Serial data line as seen at the pin |
| phy_strap | input | 5 | Strapped device address |
| irq_evt | input | 8 | One-cycle event strobes, one per interrupt flag |
| mdio_o | output | 1 | Serial data driven during reads |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| ctrl_q | output | 16 | Control register contents |
| vend_q | output | 16 | Vendor register contents |
| irq_q | output | 16 | Interrupt register: enables [15:8], flags [7:0] |
| intr_o | output | 1 | Interrupt pin level when driven |
| intr_oe | output | 1 | Interrupt pin drive enable |

## Verification
The bench builds the block with 16-bit data, 5-bit device and register addresses, and explicit defaults: 16'h1000 for control, 16'h0140 for vendor and 16'h7829 for status. The strap is set to 01011. With these values, strap-match, broadcast and foreign frames can each be sent, and the one-bit and 32-bit preambles both fit in a short run. Because the status register has a distinct value, a read-only register can be told apart from a writable one and from a zero-reading hole. The vendor default has its level bit low, so a soft reset visibly flips the interrupt polarity back.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  typedef enum logic [2:0] {
    FS_IDLE, FS_PRE, FS_ST, FS_OP, FS_ADDR, FS_TA, FS_DATA, FS_SKIP
  } frame_st_e;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_VEND = 16;
  localparam int unsigned A_IRQ  = 17;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_mgmt_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_i,
  input  logic [PHY_AW-1:0] strap,
  input  logic [DW-1:0]     rd_data,
  output logic              rd_req,
  output logic              wr_req,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DW-1:0]     wr_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int AW = PHY_AW + REG_AW;
  localparam int CW = $clog2(AW + DW + 3);
  localparam logic [CW-1:0] C_OP_END   = CW'(1);
  localparam logic [CW-1:0] C_ADDR_END = CW'(AW - 1);
  localparam logic [CW-1:0] C_TA_END   = CW'(1);
  localparam logic [CW-1:0] C_DATA_END = CW'(DW - 1);
  localparam logic [CW-1:0] C_SKIP_END = CW'(AW + DW + 1);

  frame_st_e         st;
  logic [CW-1:0]     cnt;
  logic [DW-2:0]     sh;
  logic [DW-1:0]     sh_nx;
  logic [DW-1:0]     dout;
  logic              is_rd, hit;
  logic [REG_AW-1:0] ra_q;
  logic [PHY_AW-1:0] phy_f;
  logic [REG_AW-1:0] ra_f;
  logic              addr_last, hit_f;

  // incoming bit appended to the history
  assign sh_nx     = {sh, mdio_i};
  assign phy_f     = sh_nx[AW-1:REG_AW];
  assign ra_f      = sh_nx[REG_AW-1:0];
  assign hit_f     = (phy_f == '0) || (phy_f == strap);
  assign addr_last = (st == FS_ADDR) && (cnt == C_ADDR_END);

  assign rd_req   = addr_last && is_rd && hit_f;
  assign wr_req   = (st == FS_DATA) && !is_rd && hit && (cnt == C_DATA_END);
  assign reg_addr = addr_last ? ra_f : ra_q;
  assign wr_data  = sh_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_IDLE;
      cnt     <= '0;
      sh      <= '0;
      dout    <= '0;
      is_rd   <= 1'b0;
      hit     <= 1'b0;
      ra_q    <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      sh <= sh_nx[DW-2:0];
      case (st)
        FS_IDLE: if (mdio_i) st <= FS_PRE;
        FS_PRE:  if (!mdio_i) st <= FS_ST;
        FS_ST: begin
          cnt <= '0;
          st  <= mdio_i ? FS_OP : FS_IDLE;
        end
        FS_OP: begin
          cnt <= cnt + 1'b1;
          if (cnt == C_OP_END) begin
            cnt <= '0;
            if ({sh[0], mdio_i} == OP_RD) begin
              is_rd <= 1'b1;
              st    <= FS_ADDR;
            end else if ({sh[0], mdio_i} == OP_WR) begin
              is_rd <= 1'b0;
              st    <= FS_ADDR;
            end else begin
              st <= FS_SKIP;
            end
          end
        end
        FS_ADDR: begin
          cnt <= cnt + 1'b1;
          if (addr_last) begin
            cnt  <= '0;
            hit  <= hit_f;
            ra_q <= ra_f;
            dout <= rd_data;
            st   <= FS_TA;
          end
        end
        FS_TA: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0 && is_rd && hit) begin
            mdio_oe <= 1'b1;
            mdio_o  <= 1'b0;
          end
          if (cnt == C_TA_END) begin
            cnt <= '0;
            st  <= FS_DATA;
            if (is_rd && hit) begin
              mdio_o <= dout[DW-1];
              dout   <= {dout[DW-2:0], 1'b0};
            end
          end
        end
        FS_DATA: begin
          cnt <= cnt + 1'b1;
          if (is_rd && hit) begin
            mdio_o <= dout[DW-1];
            dout   <= {dout[DW-2:0], 1'b0};
          end
          if (cnt == C_DATA_END) begin
            cnt     <= '0;
            st      <= FS_IDLE;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end
        end
        FS_SKIP: begin
          cnt <= cnt + 1'b1;
          if (cnt == C_SKIP_END) begin
            cnt <= '0;
            st  <= FS_IDLE;
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_mgmt_pkg::*;
#(
  parameter int          REG_AW   = 5,
  parameter int          DW       = 16,
  parameter logic [15:0] CTRL_DEF = 16'h1000,
  parameter logic [15:0] VEND_DEF = 16'h0140,
  parameter logic [15:0] STAT_VAL = 16'h7829,
  parameter int          SRST_BIT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW/2-1:0]   irq_evt,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     vend_q,
  output logic [DW-1:0]     irq_q
);
  localparam int IRQ_N = DW / 2;

  logic [DW-1:0]    ctrl_r, vend_r;
  logic [IRQ_N-1:0] ien_r, ist_r;
  logic             soft_rst, irq_clr;

  assign soft_rst = wr_req && (addr == REG_AW'(A_CTRL)) && wr_data[SRST_BIT];
  assign irq_clr  = rd_req && (addr == REG_AW'(A_IRQ));

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl_r <= DW'(CTRL_DEF);
      vend_r <= DW'(VEND_DEF);
      ien_r  <= '0;
    end else if (wr_req) begin
      if (addr == REG_AW'(A_CTRL)) ctrl_r <= wr_data;
      if (addr == REG_AW'(A_VEND)) vend_r <= wr_data;
      if (addr == REG_AW'(A_IRQ))  ien_r  <= wr_data[DW-1:IRQ_N];
    end
  end

  // sticky flags: a same-edge event survives the clear
  for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || soft_rst) ist_r[i] <= 1'b0;
      else if (irq_clr)    ist_r[i] <= irq_evt[i];
      else                 ist_r[i] <= ist_r[i] | irq_evt[i];
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == REG_AW'(A_CTRL)) rd_data = ctrl_r;
    if (addr == REG_AW'(A_STAT)) rd_data = DW'(STAT_VAL);
    if (addr == REG_AW'(A_VEND)) rd_data = vend_r;
    if (addr == REG_AW'(A_IRQ))  rd_data = {ien_r, ist_r};
  end

  assign ctrl_q = ctrl_r;
  assign vend_q = vend_r;
  assign irq_q  = {ien_r, ist_r};
endmodule

// File: rtl/mdio_irq_out.sv
module mdio_irq_out #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] en,
  input  logic [N-1:0] flags,
  input  logic         level,
  output logic         intr_o,
  output logic         intr_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      intr_o  <= 1'b0;
      intr_oe <= 1'b0;
    end else begin
      intr_o  <= level;
      intr_oe <= |(en & flags);
    end
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int          PHY_AW   = 5,
  parameter int          REG_AW   = 5,
  parameter int          DW       = 16,
  parameter logic [15:0] CTRL_DEF = 16'h1000,
  parameter logic [15:0] VEND_DEF = 16'h0140,
  parameter logic [15:0] STAT_VAL = 16'h7829,
  parameter int          LVL_BIT  = 14,
  parameter int          SRST_BIT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_i,
  input  logic [PHY_AW-1:0] phy_strap,
  input  logic [DW/2-1:0]   irq_evt,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     vend_q,
  output logic [DW-1:0]     irq_q,
  output logic              intr_o,
  output logic              intr_oe
);
  localparam int IRQ_N = DW / 2;

  logic              rd_req, wr_req;
  logic [REG_AW-1:0] reg_addr;
  logic [DW-1:0]     wr_data, rd_data;

  mdio_frame #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DW(DW)) frame_i (
    .clk(clk), .rst(rst), .mdio_i(mdio_i), .strap(phy_strap),
    .rd_data(rd_data), .rd_req(rd_req), .wr_req(wr_req),
    .reg_addr(reg_addr), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_regfile #(
    .REG_AW(REG_AW), .DW(DW), .CTRL_DEF(CTRL_DEF), .VEND_DEF(VEND_DEF),
    .STAT_VAL(STAT_VAL), .SRST_BIT(SRST_BIT)
  ) regs_i (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
    .addr(reg_addr), .wr_data(wr_data), .irq_evt(irq_evt),
    .rd_data(rd_data), .ctrl_q(ctrl_q), .vend_q(vend_q), .irq_q(irq_q)
  );

  mdio_irq_out #(.N(IRQ_N)) irq_i (
    .clk(clk), .rst(rst), .en(irq_q[DW-1:IRQ_N]), .flags(irq_q[IRQ_N-1:0]),
    .level(vend_q[LVL_BIT]), .intr_o(intr_o), .intr_oe(intr_oe)
  );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mdio_o,
  input logic          mdio_oe,
  input logic          intr_oe,
  input logic [DW-1:0] vend_q,
  input logic [DW-1:0] irq_q
);
  localparam int RW = $clog2(DW + 3);
  logic [RW-1:0] oe_run;

  always_ff @(posedge clk) begin
    if (rst)          oe_run <= '0;
    else if (mdio_oe) oe_run <= oe_run + 1'b1;
    else              oe_run <= '0;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!mdio_oe && !intr_oe));

  p_ta_zero_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  p_read_length_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> (oe_run == RW'(DW + 1)));

  p_intr_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_oe) |-> $past(|(irq_q[DW-1:DW/2] & irq_q[DW/2-1:0])));

  p_write_not_in_read_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(vend_q) |-> !mdio_oe);
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .intr_oe(intr_oe), .vend_q(vend_q), .irq_q(irq_q)
);

// File: tb/mdio_mgmt_slave_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_tb_top;
  localparam logic [15:0] CTRL_D = 16'h1000;
  localparam logic [15:0] VEND_D = 16'h0140;
  localparam logic [15:0] STAT_D = 16'h7829;
  localparam logic [4:0]  STRAP  = 5'h0B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdio_i = 1'b1;
  logic [7:0]  irq_evt = '0;
  logic        mdio_o, mdio_oe, intr_o, intr_oe;
  logic [15:0] ctrl_q, vend_q, irq_q;
  logic        line;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;
  assign line = mdio_oe ? mdio_o : 1'b1;

  mdio_mgmt_slave #(
    .CTRL_DEF(CTRL_D), .VEND_DEF(VEND_D), .STAT_VAL(STAT_D)
  ) dut_i (
    .clk(clk), .rst(rst), .mdio_i(mdio_i), .phy_strap(STRAP),
    .irq_evt(irq_evt), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .ctrl_q(ctrl_q), .vend_q(vend_q), .irq_q(irq_q),
    .intr_o(intr_o), .intr_oe(intr_oe)
  );

  // {read, phy, reg, write data, expected read, expect drive, req}
  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] ra;
    logic [15:0] wd;
    logic [15:0] exp;
    logic       drv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'h0B, 5'd0,  16'h0000, 16'h1000, 1'b1, 4'd2},  // R2 one-bit preamble
    '{1'b0, 5'h0B, 5'd16, 16'h4A5C, 16'h0000, 1'b0, 4'd7},  // R7 write vendor
    '{1'b1, 5'h00, 5'd16, 16'h0000, 16'h4A5C, 1'b1, 4'd4},  // R4 broadcast read
    '{1'b1, 5'h03, 5'd16, 16'h0000, 16'hFFFF, 1'b0, 4'd5},  // R5 foreign read
    '{1'b0, 5'h03, 5'd16, 16'h1234, 16'h0000, 1'b0, 4'd5},  // R5 foreign write
    '{1'b1, 5'h0B, 5'd16, 16'h0000, 16'h4A5C, 1'b1, 4'd5},  // R5 unchanged
    '{1'b0, 5'h0B, 5'd5,  16'hFFFF, 16'h0000, 1'b0, 4'd8},  // R8 hole write
    '{1'b1, 5'h0B, 5'd5,  16'h0000, 16'h0000, 1'b1, 4'd8},  // R8 hole reads 0
    '{1'b1, 5'h0B, 5'd1,  16'h0000, 16'h7829, 1'b1, 4'd8},  // R8 status value
    '{1'b0, 5'h0B, 5'd1,  16'h0000, 16'h0000, 1'b0, 4'd8},  // R8 status write
    '{1'b1, 5'h0B, 5'd1,  16'h0000, 16'h7829, 1'b1, 4'd8},  // R8 read-only
    '{1'b0, 5'h0B, 5'd0,  16'h0123, 16'h0000, 1'b0, 4'd3},  // R3 write control
    '{1'b1, 5'h0B, 5'd0,  16'h0000, 16'h0123, 1'b1, 4'd3}   // R3 read control
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk);
    mdio_i = b;
  endtask

  task automatic hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                     input int npre, input logic [7:0] evt);
    repeat (npre) bit_out(1'b1);
    bit_out(1'b0);
    bit_out(1'b1);
    bit_out(op[1]);
    bit_out(op[0]);
    for (int i = 4; i >= 0; i--) bit_out(phy[i]);
    for (int i = 4; i >= 1; i--) bit_out(ra[i]);
    @(negedge clk);
    mdio_i  = ra[0];
    irq_evt = evt;
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] ra, input int npre,
                         input logic [7:0] evt, output logic [15:0] data,
                         output logic ta1_oe, output logic ta2_oe, output logic ta2_line,
                         output logic any_oe, output logic end_oe);
    hdr(OP_RD_T, phy, ra, npre, evt);
    @(negedge clk); mdio_i = 1'b1; irq_evt = '0;
    ta1_oe = mdio_oe;
    any_oe = mdio_oe;
    @(negedge clk);
    ta2_oe = mdio_oe; ta2_line = line;
    any_oe |= mdio_oe;
    data = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      data = {data[14:0], line};
      any_oe |= mdio_oe;
    end
    @(negedge clk);
    end_oe = mdio_oe;
  endtask

  task automatic do_write(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] wd, output logic [15:0] vend_before);
    hdr(op, phy, ra, 1, 8'h00);
    @(negedge clk); mdio_i = 1'b1; irq_evt = '0;
    bit_out(1'b0);
    for (int i = 15; i >= 0; i--) bit_out(wd[i]);
    vend_before = vend_q;
    @(negedge clk); mdio_i = 1'b1;
  endtask

  localparam logic [1:0] OP_RD_T = 2'b10;
  localparam logic [1:0] OP_WR_T = 2'b01;

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk); irq_evt = ev;
    @(negedge clk); irq_evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d, vb;
    logic t1, t2, tl, ao, eo;
    repeat (4) @(negedge clk);
    chk("R1 mdio_oe in reset", mdio_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mdio_oe", mdio_oe, 0);
    chk("R1 intr_oe", intr_oe, 0);
    chk("R1 ctrl", ctrl_q, CTRL_D);
    chk("R1 vend", vend_q, VEND_D);
    chk("R1 irq", irq_q, 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VECS[v].req, v);
      if (VECS[v].rd) begin
        do_read(VECS[v].phy, VECS[v].ra, 1, 8'h00, d, t1, t2, tl, ao, eo);
        chk(tag, d, VECS[v].exp);
        if (VECS[v].drv) begin
          chk({tag, " R6 ta1 released"}, t1, 0);
          chk({tag, " R6 ta2 driven zero"}, {t2, tl}, 2'b10);
          chk({tag, " R6 released after"}, eo, 0);
        end else begin
          chk({tag, " R5 never driven"}, ao, 0);
        end
      end else begin
        do_write(OP_WR_T, VECS[v].phy, VECS[v].ra, VECS[v].wd, vb);
      end
    end

    // R7: not visible before the sixteenth data bit edge, visible after
    do_write(OP_WR_T, STRAP, 5'd16, 16'h4000, vb);
    chk("R7 before commit", vb, 16'h4A5C);
    chk("R7 after commit", vend_q, 16'h4000);

    // R3: opcodes 11 and 00 ignored
    do_write(2'b11, STRAP, 5'd16, 16'h1111, vb);
    do_write(2'b00, STRAP, 5'd16, 16'h2222, vb);
    chk("R3 bad opcodes ignored", vend_q, 16'h4000);

    // R2: full 32-bit preamble
    do_read(STRAP, 5'd0, 32, 8'h00, d, t1, t2, tl, ao, eo);
    chk("R2 long preamble read", d, 16'h0123);

    // R4/R9: broadcast write of enables for flags 0 and 2
    do_write(OP_WR_T, 5'h00, 5'd17, 16'h05FF, vb);
    chk("R9 enables written, flags untouched", irq_q, 16'h0500);

    pulse(8'h02);
    @(negedge clk);
    chk("R9 unenabled flag no intr", intr_oe, 0);
    chk("R9 flag 1 set", irq_q, 16'h0502);

    pulse(8'h04);
    chk("R9 intr one clock later", intr_oe, 0);
    @(negedge clk);
    chk("R9 intr asserted", intr_oe, 1);
    chk("R10 active high level", intr_o, 1);

    do_write(OP_WR_T, STRAP, 5'd16, 16'h0000, vb);
    @(negedge clk);
    chk("R10 active low level", {intr_oe, intr_o}, 2'b10);

    // R11: read clears, same-edge event survives
    do_read(STRAP, 5'd17, 1, 8'h01, d, t1, t2, tl, ao, eo);
    chk("R11 read returns flags", d, 16'h0506);
    chk("R11 same-edge event kept", irq_q, 16'h0501);
    chk("R9 still pending", intr_oe, 1);
    do_read(STRAP, 5'd17, 1, 8'h00, d, t1, t2, tl, ao, eo);
    chk("R11 second read", d, 16'h0501);
    chk("R11 flags cleared", irq_q, 16'h0500);
    chk("R9 intr released", intr_oe, 0);

    // R12: soft reset
    do_write(OP_WR_T, STRAP, 5'd16, 16'h1234, vb);
    pulse(8'h01);
    do_write(OP_WR_T, STRAP, 5'd0, 16'h8000, vb);
    chk("R12 ctrl default", ctrl_q, CTRL_D);
    chk("R12 vend default", vend_q, VEND_D);
    chk("R12 irq cleared", irq_q, 0);
    do_read(STRAP, 5'd0, 1, 8'h00, d, t1, t2, tl, ao, eo);
    chk("R12 bit 15 reads 0", d, CTRL_D);
    chk("R12 intr idle", intr_oe, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule